// File: doc/BRIEF.md
# Bus Clock Ratio Chain

This block derives four slower clocks from a CPU core clock by integer division. It works as a chain. A system bus stage divides the core clock. A peripheral stage halves the system bus clock. A memory stage runs the system bus clock at full or half rate. A static bus stage divides the peripheral clock. Every stage is a counter that runs on the core clock and advances only on the wrap of its parent stage, so all derived clocks rise on the same core edge as their parents.

The ratios come from configuration fields. They are captured once, on the first clock edge after reset is released, and held from then on. A parameter selects the chip variant. The newer variant takes the memory ratio from a configuration bit and the static bus divisor from a 3-bit field. The legacy variant always halves the memory clock and chooses between two fixed static bus divisors with a single bit. The effective ratios are read back on output ports.

The control is a two-state machine. `ST_LOAD` is held throughout reset and makes the ratio capture. `ST_RUN` is entered by the transition `LOAD_TO_RUN` on the first edge after reset release, and the stages count only in this state. A transition `RUN_HOLD` keeps the block in `ST_RUN`. Asserting reset returns it asynchronously to `ST_LOAD`.

Top module: `clkdiv_chain`

## Requirements
- R1: The system bus ratio read back on `rb_sys` is `pwr_sel + 2` (2 to 5), and `sys_clk` repeats with that period in core cycles.
- R2: `per_clk` has twice the period of `sys_clk`. It is high for exactly one system bus period and rises on the same core edge as `sys_clk`.
- R3: In the newer variant (`LEGACY = 0`), the memory ratio is 1 when `mem_fast` is 1, and then `mem_clk` equals `sys_clk`. It is 2 when `mem_fast` is 0, and then `mem_clk` equals `per_clk`. `rb_mem` reads 1 or 2 accordingly.
- R4: In the legacy variant (`LEGACY = 1`), `mem_fast` is ignored: `rb_mem` reads 2 and `mem_clk` follows `per_clk`.
- R5: In the newer variant, the static bus ratio is `st_cfg[15:13] + 1` (1 to 8) peripheral periods. With ratio 1, `sbus_clk` equals `per_clk`.
- R6: In the legacy variant, the static bus ratio is 5 when `st_cfg[11]` is 1 and 4 when it is 0. The other bits of `st_cfg` are ignored.
- R7: The configuration inputs are captured on the first rising edge after `rst_n` goes high. Later changes to them alter neither the clocks nor the read-back values.
- R8: While `rst_n` is low, all four clocks and all read-back ports are 0. In the first core cycle after the capture edge, all four clocks are high.
- R9: For an odd ratio N, a stage's high phase lasts (N+1)/2 parent periods and its low phase lasts (N-1)/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_sel | input | 2 | System bus ratio select (ratio = value + 2) |
| mem_fast | input | 1 | Memory clock at system bus rate when 1 (newer variant only) |
| st_cfg | input | 16 | Static bus configuration word; bit 11 used by the legacy variant, bits 15:13 by the newer one |
| sys_clk | output | 1 | System bus clock |
| per_clk | output | 1 | Peripheral clock |
| mem_clk | output | 1 | Memory clock |
| sbus_clk | output | 1 | Static bus clock |
| rb_sys | output | 3 | Effective system bus ratio, 0 during reset |
| rb_mem | output | 2 | Effective memory ratio relative to system bus, 0 during reset |
| rb_sbus | output | 4 | Effective static bus ratio relative to peripheral clock, 0 during reset |

## Verification
The chain is run with six configuration sets, and each set drives a newer-variant and a legacy-variant instance side by side. Together the sets cover all four system bus ratios, even and odd. They also cover both memory settings and static bus fields from 1 to 8, including the pass-through ratio 1 and the odd ratios that expose an unequal duty cycle. Every core cycle of two full static bus periods is compared against a waveform computed from the ratios. This separates a wrong divisor from a wrong phase or a wrong high-phase length. The inputs are flipped a few cycles into each run to show that the captured ratios hold, and the two instances show how the variant changes the decode of the same inputs.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int SYS_W  = 3;
    localparam int PER_W  = 2;
    localparam int MEM_W  = 2;
    localparam int SB_W   = 4;
    localparam int PWR_W  = 2;
    localparam int STC_W  = 16;

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } chain_state_e;
endpackage

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick_in,
    input  logic          par_lvl,
    input  logic [CW-1:0] ratio,
    output logic          tick_out,
    output logic          lvl_out
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW:0]   ONEW = (CW + 1)'(1);

    logic [CW-1:0] cnt_q;
    logic [CW:0]   hi_len;
    logic          wrap;

    assign wrap   = (cnt_q == ratio - ONE);
    assign hi_len = ({1'b0, ratio} + ONEW) >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick_in) begin
            cnt_q <= wrap ? '0 : cnt_q + ONE;
        end
    end

    assign tick_out = run & tick_in & wrap;

    always_comb begin
        if (ratio == ONE) begin
            lvl_out = par_lvl;
        end else begin
            lvl_out = run & ({1'b0, cnt_q} < hi_len);
        end
    end
endmodule

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
    import clkdiv_pkg::*;
#(
    parameter bit LEGACY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [PWR_W-1:0] pwr_sel,
    input  logic             mem_fast,
    input  logic [STC_W-1:0] st_cfg,
    output logic [SYS_W-1:0] sys_ratio,
    output logic [MEM_W-1:0] mem_ratio,
    output logic [SB_W-1:0]  sb_ratio
);
    logic [MEM_W-1:0] mem_dec;
    logic [SB_W-1:0]  sb_dec;
    logic             cfg_unused;

    generate
        if (LEGACY) begin : g_legacy
            assign mem_dec    = MEM_W'(2);
            assign sb_dec     = st_cfg[11] ? SB_W'(5) : SB_W'(4);
            assign cfg_unused = ^{mem_fast, st_cfg[15:12], st_cfg[10:0]};
        end else begin : g_newer
            assign mem_dec    = mem_fast ? MEM_W'(1) : MEM_W'(2);
            assign sb_dec     = SB_W'(st_cfg[15:13]) + SB_W'(1);
            assign cfg_unused = ^st_cfg[12:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_ratio <= SYS_W'(2);
            mem_ratio <= MEM_W'(2);
            sb_ratio  <= SB_W'(4);
        end else if (capture) begin
            sys_ratio <= SYS_W'(pwr_sel) + SYS_W'(2);
            mem_ratio <= mem_dec;
            sb_ratio  <= sb_dec;
        end
    end
endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
    import clkdiv_pkg::*;
#(
    parameter bit LEGACY = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  pwr_sel,
    input  logic        mem_fast,
    input  logic [15:0] st_cfg,
    output logic        sys_clk,
    output logic        per_clk,
    output logic        mem_clk,
    output logic        sbus_clk,
    output logic [2:0]  rb_sys,
    output logic [1:0]  rb_mem,
    output logic [3:0]  rb_sbus
);
    chain_state_e state_q, state_d;
    logic run, capture;
    logic [SYS_W-1:0] sys_ratio;
    logic [MEM_W-1:0] mem_ratio;
    logic [SB_W-1:0]  sb_ratio;
    logic sys_tick, per_tick, mem_tick_unused, sb_tick_unused;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        run     = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                capture = 1'b1;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                run     = 1'b1;
                state_d = ST_RUN;
            end
        endcase
    end

    clkdiv_cfg #(.LEGACY(LEGACY)) u_cfg (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .pwr_sel(pwr_sel), .mem_fast(mem_fast), .st_cfg(st_cfg),
        .sys_ratio(sys_ratio), .mem_ratio(mem_ratio), .sb_ratio(sb_ratio)
    );

    clkdiv_stage #(.CW(SYS_W)) u_sys (
        .clk(clk), .rst_n(rst_n), .run(run), .tick_in(run), .par_lvl(1'b0),
        .ratio(sys_ratio), .tick_out(sys_tick), .lvl_out(sys_clk)
    );

    clkdiv_stage #(.CW(PER_W)) u_per (
        .clk(clk), .rst_n(rst_n), .run(run), .tick_in(sys_tick), .par_lvl(sys_clk),
        .ratio(PER_W'(2)), .tick_out(per_tick), .lvl_out(per_clk)
    );

    clkdiv_stage #(.CW(MEM_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .run(run), .tick_in(sys_tick), .par_lvl(sys_clk),
        .ratio(mem_ratio), .tick_out(mem_tick_unused), .lvl_out(mem_clk)
    );

    clkdiv_stage #(.CW(SB_W)) u_sbus (
        .clk(clk), .rst_n(rst_n), .run(run), .tick_in(per_tick), .par_lvl(per_clk),
        .ratio(sb_ratio), .tick_out(sb_tick_unused), .lvl_out(sbus_clk)
    );

    assign rb_sys  = run ? sys_ratio : '0;
    assign rb_mem  = run ? mem_ratio : '0;
    assign rb_sbus = run ? sb_ratio  : '0;
endmodule

// File: rtl/clkdiv_chain_chk.sv
module clkdiv_chain_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_clk,
    input logic       per_clk,
    input logic       mem_clk,
    input logic       sbus_clk,
    input logic [2:0] rb_sys,
    input logic [1:0] rb_mem,
    input logic [3:0] rb_sbus
);
    AST_SYS_RATIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_sys != 3'd0) |-> (rb_sys >= 3'd2 && rb_sys <= 3'd5)); // R1

    AST_PER_ON_SYS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_sys != 3'd0 && !$stable(per_clk)) |-> $rose(sys_clk)); // R2

    AST_MEM_FAST_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_mem == 2'd1) |-> (mem_clk == sys_clk)); // R3

    AST_MEM_SLOW_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_mem == 2'd2) |-> (mem_clk == per_clk)); // R3

    AST_SBUS_ON_PER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_sbus > 4'd1 && !$stable(sbus_clk)) |-> $rose(per_clk)); // R5

    AST_RATIOS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_sys != 3'd0 && $past(rb_sys) != 3'd0)
            |-> ($stable(rb_sys) && $stable(rb_mem) && $stable(rb_sbus))); // R7

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_sys == 3'd0) |-> !(sys_clk | per_clk | mem_clk | sbus_clk)); // R8
endmodule

bind clkdiv_chain clkdiv_chain_chk u_chk (.*);

// File: tb/clkdiv_chain_tb.sv
`timescale 1ns/1ps
module clkdiv_chain_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pwr_sel = '0;
    logic        mem_fast = 1'b0;
    logic [15:0] st_cfg = '0;

    logic       n_sys, n_per, n_mem, n_sb, o_sys, o_per, o_mem, o_sb;
    logic [2:0] n_rbs, o_rbs;
    logic [1:0] n_rbm, o_rbm;
    logic [3:0] n_rbq, o_rbq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    clkdiv_chain #(.LEGACY(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_sel(pwr_sel), .mem_fast(mem_fast), .st_cfg(st_cfg),
        .sys_clk(n_sys), .per_clk(n_per), .mem_clk(n_mem), .sbus_clk(n_sb),
        .rb_sys(n_rbs), .rb_mem(n_rbm), .rb_sbus(n_rbq)
    );

    clkdiv_chain #(.LEGACY(1'b1)) u_dut_legacy (
        .clk(clk), .rst_n(rst_n), .pwr_sel(pwr_sel), .mem_fast(mem_fast), .st_cfg(st_cfg),
        .sys_clk(o_sys), .per_clk(o_per), .mem_clk(o_mem), .sbus_clk(o_sb),
        .rb_sys(o_rbs), .rb_mem(o_rbm), .rb_sbus(o_rbq)
    );

    // stimulus {pwr[1:0], mem_fast, f[2:0], b11} (7 bits)
    localparam int NV = 6;
    localparam logic [6:0] VEC [NV] = '{
        {2'd0, 1'b1, 3'd0, 1'b0},
        {2'd1, 1'b0, 3'd2, 1'b1},
        {2'd2, 1'b1, 3'd7, 1'b0},
        {2'd3, 1'b0, 3'd4, 1'b1},
        {2'd1, 1'b1, 3'd1, 1'b0},
        {2'd0, 1'b0, 3'd6, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // independent waveform model; which: 0 sys,1 per,2 mem,3 sbus
    function automatic logic model(input int k, input int s, input int m, input int q, input int which);
        logic sl, pl;
        sl = (k % s) < ((s + 1) / 2);
        pl = ((k / s) % 2) == 0;
        case (which)
            0: return sl;
            1: return pl;
            2: return (m == 1) ? sl : pl;
            default: return (q == 1) ? pl : (((k / (2 * s)) % q) < ((q + 1) / 2));
        endcase
    endfunction

    task automatic run_vec(input logic [6:0] v);
        int s, mn, qn, qo, len;
        int mis[8];
        logic [15:0] sc;
        s  = int'(v[6:5]) + 2;                  // R1
        mn = v[4] ? 1 : 2;                       // R3
        qn = int'(v[3:1]) + 1;                   // R5
        qo = v[0] ? 5 : 4;                       // R6
        sc = {v[3:1], 1'b0, v[0], 11'h5a3};
        foreach (mis[i]) mis[i] = 0;
        @(negedge clk);
        rst_n = 1'b0;
        pwr_sel = v[6:5]; mem_fast = v[4]; st_cfg = sc;
        repeat (2) @(negedge clk);
        chk("R8 outputs in reset", int'({n_sys, n_per, n_mem, n_sb, o_sys, o_per, o_mem, o_sb}), 0);
        chk("R8 readback in reset", int'({n_rbs, n_rbm, n_rbq, o_rbs, o_rbm, o_rbq}), 0);
        rst_n = 1'b1;
        len = 2 * 2 * s * ((qn > qo) ? qn : qo);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (k == 0) begin
                chk("R8 first run cycle all high", int'({n_sys, n_per, n_mem, n_sb, o_sys, o_per, o_mem, o_sb}), 255);
            end
            if (k == 2) begin          // R7: flip inputs after capture
                pwr_sel = ~v[6:5]; mem_fast = ~v[4]; st_cfg = ~sc;
            end
            if (n_sys !== model(k, s, mn, qn, 0)) mis[0]++;
            if (n_per !== model(k, s, mn, qn, 1)) mis[1]++;
            if (n_mem !== model(k, s, mn, qn, 2)) mis[2]++;
            if (n_sb  !== model(k, s, mn, qn, 3)) mis[3]++;
            if (o_sys !== model(k, s, 2, qo, 0)) mis[4]++;
            if (o_per !== model(k, s, 2, qo, 1)) mis[5]++;
            if (o_mem !== model(k, s, 2, qo, 2)) mis[6]++;
            if (o_sb  !== model(k, s, 2, qo, 3)) mis[7]++;
        end
        chk("R1 R9 sys_clk mismatches", mis[0] + mis[4], 0);
        chk("R2 per_clk mismatches", mis[1] + mis[5], 0);
        chk("R3 mem_clk newer mismatches", mis[2], 0);
        chk("R4 mem_clk legacy mismatches", mis[6], 0);
        chk("R5 R9 sbus_clk newer mismatches", mis[3], 0);
        chk("R6 sbus_clk legacy mismatches", mis[7], 0);
        chk("R1 R7 rb_sys", int'(n_rbs) * 8 + int'(o_rbs), s * 8 + s);
        chk("R3 R7 rb_mem newer", int'(n_rbm), mn);
        chk("R4 rb_mem legacy", int'(o_rbm), 2);
        chk("R5 R7 rb_sbus newer", int'(n_rbq), qn);
        chk("R6 R7 rb_sbus legacy", int'(o_rbq), qo);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 outputs at start", int'({n_sys, n_per, n_mem, n_sb, o_sys, o_per, o_mem, o_sb}), 0);
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);
        // directed corner: legacy with mem_fast high and odd static ratio, fastest sys
        run_vec({2'd0, 1'b1, 3'd0, 1'b1});
        // directed corner: widest static field, odd system ratio
        run_vec({2'd3, 1'b1, 3'd7, 1'b0});
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule